// File: doc/BRIEF.md
# Slave-Timed Serial Frame Output Port

This block serialises one frame of timeslot bytes onto a single data line and puts a per-channel signaling stream beside it. The port does not own its timing. A system-side bit clock and a frame pulse arrive from outside. The block runs on a fast core clock and oversamples both of them. It then derives the moments at which it samples the pulse and the moments at which it moves the outputs on by one bit.

Several options are set by static configuration inputs:
- the bit-clock edge that samples the frame pulse;
- a separate bit-clock edge that advances the outputs;
- the frame-pulse polarity;
- a double-rate bit clock, with two clock cycles per bit, together with the choice of which of the two candidate edges advances the data;
- a start delay of whole channels plus bits between the accepted pulse and the first bit of the frame;
- a choice between a 256-bit frame and a 193-bit frame.

In the 256-bit frame, 32 slots are carried. In the 193-bit frame, one framing bit is followed by 24 channels. The slot bytes and signaling nibbles come from an external buffer, and this block only reads them.

Top module: `frm_slave_tx`

## Requirements
- R1: After reset, `ser_dat_o` and `ser_sig_o` are 0. They stay 0 at every update until a first frame pulse has been accepted.
- R2: The pulse is active high when `cfg_fp_inv_i`=0 and active low when it is 1. It is sampled on bit-clock rising edges when `cfg_fp_fall_i`=0 and on falling edges when it is 1.
- R3: The outputs change only after a data-update edge. Data-update edges are rising edges when `cfg_dat_fall_i`=0 and falling edges when it is 1.
- R4: Stream position 0 is carried by the first update edge that coincides with or follows the edge on which the pulse is accepted. When the two edge choices differ, the pulse therefore leads the data by half a clock cycle. Each later update advances the position by one.
- R5: With `cfg_x2_i`=1, a bit lasts two bit-clock cycles. Only the first sampling edge of a bit can accept a pulse, and the very first sighting after reset defines that first edge. `cfg_x2_late_i`=0 updates on the first candidate edge of the bit and 1 updates on the second.
- R6: With `cfg_e1_i`=1, a frame is 256 bits. Frame bit f carries `slot_data_i[(f/8)*8 + 7 - f%8]`, so each slot is sent most significant bit first.
- R7: With `cfg_e1_i`=0, a frame is 193 bits. Frame bit 0 is `t1_fbit_i`, and frame bit f≥1 is channel (f-1)/8, bit 7-(f-1)%8, drawn from slots 0 to 23.
- R8: Frame bit f is output at stream position (f + 8·`cfg_ch_ofs_i` + `cfg_bit_ofs_i`) modulo the frame length.
- R9: On `ser_sig_o`, the signaling nibble `slot_sig_i[4t+3:4t]` of channel t is sent at channel bits 4 to 7, bit 3 first. The line is 0 at channel bits 0 to 3 and at the framing bit.
- R10: Without a new pulse, the stream position wraps from frame length minus one to 0 and the output keeps repeating the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | System-side bit clock |
| fp_i | input | 1 | System-side frame pulse |
| cfg_fp_fall_i | input | 1 | Pulse sampling edge: 0 rising, 1 falling |
| cfg_dat_fall_i | input | 1 | Data update edge: 0 rising, 1 falling |
| cfg_x2_i | input | 1 | Bit clock at twice the bit rate |
| cfg_x2_late_i | input | 1 | In the double-rate case, update on the second candidate edge |
| cfg_fp_inv_i | input | 1 | Frame pulse active low |
| cfg_e1_i | input | 1 | 1: 256-bit frame, 0: 193-bit frame |
| cfg_bit_ofs_i | input | 3 | Bit part of the start delay |
| cfg_ch_ofs_i | input | CHW (5) | Channel part of the start delay |
| t1_fbit_i | input | 1 | Framing bit for the 193-bit frame |
| slot_data_i | input | NUM_TS*8 | Slot bytes, slot t at bits 8t+7..8t |
| slot_sig_i | input | NUM_TS*4 | Signaling nibbles, slot t at bits 4t+3..4t |
| ser_dat_o | output | 1 | Serial data line |
| ser_sig_o | output | 1 | Serial signaling line, channel-aligned with data |

## Verification
The bench aims at the edge relation between pulse and data. A design that miscounted it would emit every frame one position early or late when the two edge choices agree or differ.

In double-rate mode, the pulse is held over both sampling edges of a bit. A design that let the second edge restart the frame would shift the whole stream by one.

The 193-bit frame gets a start delay larger than the frame. A design that failed to reduce it would mis-place the framing bit.

A single-pulse run goes past the frame end to expose a counter that stalls or restarts at the wrong count. Runs also read the signaling line on the first half of each channel, where a design must stay quiet.

// File: rtl/frm_tx_pkg.sv
package frm_tx_pkg;

   localparam int BYTE_BITS = 8;
   localparam int SIG_BITS  = 4;

   typedef enum logic {
      FMT_193 = 1'b0,
      FMT_256 = 1'b1
   } frame_fmt_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } clk_ev_t;

endpackage

// File: rtl/frm_tx_sync.sv
module frm_tx_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [WIDTH-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
            end else begin
               stg_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign q_o = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/frm_tx_phase.sv
module frm_tx_phase
   import frm_tx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ser_s_i,
   input  logic fp_s_i,
   input  logic cfg_fp_fall_i,
   input  logic cfg_dat_fall_i,
   input  logic cfg_fp_inv_i,
   input  logic cfg_x2_i,
   input  logic cfg_x2_late_i,
   output logic hit_o,
   output logic upd_o
);

   logic    ser_q;
   logic    ph_q;
   logic    lock_q;
   clk_ev_t ev;
   logic    fp_edge;
   logic    dat_edge;
   logic    fp_act;
   logic    cur_ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ser_q <= 1'b0;
      else        ser_q <= ser_s_i;
   end

   assign ev.rise  = ser_s_i & ~ser_q;
   assign ev.fall  = ~ser_s_i & ser_q;
   assign fp_edge  = cfg_fp_fall_i  ? ev.fall : ev.rise;
   assign dat_edge = cfg_dat_fall_i ? ev.fall : ev.rise;
   assign fp_act   = fp_s_i ^ cfg_fp_inv_i;

   // Phase of the current bit period: 0 = first clock cycle of the bit.
   always_comb begin
      cur_ph = ph_q;
      hit_o  = 1'b0;
      if (fp_edge) begin
         if (!cfg_x2_i) begin
            cur_ph = 1'b0;
            hit_o  = fp_act;
         end else if (!lock_q) begin
            cur_ph = fp_act ? 1'b0 : ~ph_q;
            hit_o  = fp_act;
         end else begin
            cur_ph = ~ph_q;
            hit_o  = fp_act & ~cur_ph;
         end
      end
   end

   assign upd_o = dat_edge & (~cfg_x2_i | (cur_ph == cfg_x2_late_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= 1'b0;
         lock_q <= 1'b0;
      end else begin
         if (fp_edge) ph_q <= cur_ph;
         if (hit_o)   lock_q <= 1'b1;
      end
   end

   // R5: once the bit phase is locked it stays locked
   a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R5: an accepted pulse always marks the first half of a bit
   a_r5_hit_first_phase: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> (ph_q == 1'b0) && lock_q);

endmodule

// File: rtl/frm_tx_pos.sv
module frm_tx_pos #(
   parameter int LEN_256 = 256,
   parameter int LEN_193 = 193,
   parameter int POS_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_i,
   input  logic             upd_i,
   input  logic             cfg_e1_i,
   output logic [POS_W-1:0] pos_nxt_o,
   output logic             sync_nxt_o,
   output logic             sync_o
);

   logic [POS_W-1:0] pos_q;
   logic             sync_q;
   logic             pend_q;
   logic             pend_nxt;
   logic [POS_W-1:0] last_pos;

   assign last_pos = cfg_e1_i ? POS_W'(LEN_256 - 1) : POS_W'(LEN_193 - 1);

   always_comb begin
      pos_nxt_o  = pos_q;
      sync_nxt_o = sync_q;
      pend_nxt   = pend_q;
      if (upd_i) begin
         if (hit_i || pend_q) begin
            pos_nxt_o  = '0;
            sync_nxt_o = 1'b1;
            pend_nxt   = 1'b0;
         end else if (pos_q >= last_pos) begin
            pos_nxt_o = '0;
         end else begin
            pos_nxt_o = pos_q + 1'b1;
         end
      end else if (hit_i) begin
         pend_nxt = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         sync_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         pos_q  <= pos_nxt_o;
         sync_q <= sync_nxt_o;
         pend_q <= pend_nxt;
      end
   end

   assign sync_o = sync_q;

   // R4: a pulse on an update edge restarts the stream at position 0
   a_r4_pulse_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && upd_i) |=> (pos_q == '0) && sync_q);

   // R10: the position never leaves the active frame length
   a_r10_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= last_pos);

endmodule

// File: rtl/frm_tx_map.sv
module frm_tx_map #(
   parameter int NUM_TS  = 32,
   parameter int CHW     = 5,
   parameter int POS_W   = 8,
   parameter int LEN_256 = 256,
   parameter int LEN_193 = 193
) (
   input  logic [POS_W-1:0]    pos_i,
   input  logic                cfg_e1_i,
   input  logic [2:0]          cfg_bit_ofs_i,
   input  logic [CHW-1:0]      cfg_ch_ofs_i,
   input  logic                t1_fbit_i,
   input  logic [NUM_TS*8-1:0] slot_data_i,
   input  logic [NUM_TS*4-1:0] slot_sig_i,
   output logic                dat_o,
   output logic                sig_o
);

   localparam int SW = POS_W + 1;

   logic [SW-1:0]    len;
   logic [SW-1:0]    ofs;
   logic [SW-1:0]    ofs_m;
   logic [SW-1:0]    pos_w;
   logic [SW-1:0]    fbit_idx;
   logic [SW-1:0]    chan_idx;
   logic [CHW-1:0]   ts;
   logic [2:0]       bpos;
   logic             is_frame_bit;

   assign len   = cfg_e1_i ? SW'(LEN_256) : SW'(LEN_193);
   assign ofs   = SW'({cfg_ch_ofs_i, cfg_bit_ofs_i});
   assign ofs_m = (ofs >= len) ? ofs - len : ofs;
   assign pos_w = SW'(pos_i);

   always_comb begin
      if (pos_w >= ofs_m) fbit_idx = pos_w - ofs_m;
      else                fbit_idx = pos_w + len - ofs_m;
   end

   assign is_frame_bit = ~cfg_e1_i & (fbit_idx == '0);
   assign chan_idx     = cfg_e1_i ? fbit_idx : fbit_idx - 1'b1;
   assign ts           = chan_idx[POS_W-1:3];
   assign bpos         = chan_idx[2:0];

   always_comb begin
      if (is_frame_bit) begin
         dat_o = t1_fbit_i;
         sig_o = 1'b0;
      end else begin
         dat_o = slot_data_i[{ts, ~bpos}];
         sig_o = bpos[2] & slot_sig_i[{ts, ~bpos[1:0]}];
      end
   end

endmodule

// File: rtl/frm_slave_tx.sv
module frm_slave_tx
   import frm_tx_pkg::*;
#(
   parameter int NUM_TS      = 32,
   parameter int T1_CH       = 24,
   parameter int SYNC_STAGES = 2,
   localparam int CHW        = $clog2(NUM_TS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ser_clk_i,
   input  logic                        fp_i,
   input  logic                        cfg_fp_fall_i,
   input  logic                        cfg_dat_fall_i,
   input  logic                        cfg_x2_i,
   input  logic                        cfg_x2_late_i,
   input  logic                        cfg_fp_inv_i,
   input  logic                        cfg_e1_i,
   input  logic [2:0]                  cfg_bit_ofs_i,
   input  logic [CHW-1:0]              cfg_ch_ofs_i,
   input  logic                        t1_fbit_i,
   input  logic [NUM_TS*BYTE_BITS-1:0] slot_data_i,
   input  logic [NUM_TS*SIG_BITS-1:0]  slot_sig_i,
   output logic                        ser_dat_o,
   output logic                        ser_sig_o
);

   localparam int POS_W   = CHW + 3;
   localparam int LEN_256 = NUM_TS * BYTE_BITS;
   localparam int LEN_193 = T1_CH * BYTE_BITS + 1;

   generate
      if (NUM_TS != (1 << CHW)) begin : g_bad_ts
         $error("NUM_TS must be a power of two");
      end
      if (LEN_193 > LEN_256) begin : g_bad_t1
         $error("T1_CH channels do not fit in NUM_TS slots");
      end
      if (2 * LEN_193 <= (1 << POS_W) - 1) begin : g_bad_ofs
         $error("largest start delay must stay below twice the short frame");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [1:0]       raw_in;
   logic [1:0]       syn_in;
   logic             hit;
   logic             upd;
   logic [POS_W-1:0] pos_nxt;
   logic             sync_nxt;
   logic             sync_q;
   logic             map_dat;
   logic             map_sig;
   frame_fmt_e       fmt;

   assign raw_in = {ser_clk_i, fp_i};
   assign fmt    = frame_fmt_e'(cfg_e1_i);

   frm_tx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (syn_in)
   );

   frm_tx_phase u_phase (
      .clk            (clk),
      .rst_n          (rst_n),
      .ser_s_i        (syn_in[1]),
      .fp_s_i         (syn_in[0]),
      .cfg_fp_fall_i  (cfg_fp_fall_i),
      .cfg_dat_fall_i (cfg_dat_fall_i),
      .cfg_fp_inv_i   (cfg_fp_inv_i),
      .cfg_x2_i       (cfg_x2_i),
      .cfg_x2_late_i  (cfg_x2_late_i),
      .hit_o          (hit),
      .upd_o          (upd)
   );

   frm_tx_pos #(.LEN_256(LEN_256), .LEN_193(LEN_193), .POS_W(POS_W)) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (hit),
      .upd_i      (upd),
      .cfg_e1_i   (fmt == FMT_256),
      .pos_nxt_o  (pos_nxt),
      .sync_nxt_o (sync_nxt),
      .sync_o     (sync_q)
   );

   frm_tx_map #(
      .NUM_TS(NUM_TS), .CHW(CHW), .POS_W(POS_W),
      .LEN_256(LEN_256), .LEN_193(LEN_193)
   ) u_map (
      .pos_i         (pos_nxt),
      .cfg_e1_i      (fmt == FMT_256),
      .cfg_bit_ofs_i (cfg_bit_ofs_i),
      .cfg_ch_ofs_i  (cfg_ch_ofs_i),
      .t1_fbit_i     (t1_fbit_i),
      .slot_data_i   (slot_data_i),
      .slot_sig_i    (slot_sig_i),
      .dat_o         (map_dat),
      .sig_o         (map_sig)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_dat_o <= 1'b0;
         ser_sig_o <= 1'b0;
      end else if (upd) begin
         ser_dat_o <= sync_nxt & map_dat;
         ser_sig_o <= sync_nxt & map_sig;
      end
   end

   // R3: outputs hold between data-update edges
   a_r3_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(ser_dat_o) && $stable(ser_sig_o));

   // R1: nothing is driven before the first accepted pulse
   a_r1_idle_until_sync: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_q |-> !ser_dat_o && !ser_sig_o);

endmodule

// File: tb/frm_slave_tx_tb.sv
module frm_slave_tx_tb;

   localparam int NUM_TS = 32;
   localparam int T1_CH  = 24;
   localparam int H      = 6;
   localparam int P0     = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic                ser_clk_i = 1'b0;
   logic                fp_i = 1'b0;
   logic                cfg_fp_fall_i = 1'b0;
   logic                cfg_dat_fall_i = 1'b0;
   logic                cfg_x2_i = 1'b0;
   logic                cfg_x2_late_i = 1'b0;
   logic                cfg_fp_inv_i = 1'b0;
   logic                cfg_e1_i = 1'b1;
   logic [2:0]          cfg_bit_ofs_i = '0;
   logic [4:0]          cfg_ch_ofs_i = '0;
   logic                t1_fbit_i = 1'b0;
   logic [NUM_TS*8-1:0] slot_data_i = '0;
   logic [NUM_TS*4-1:0] slot_sig_i = '0;
   logic                ser_dat_o;
   logic                ser_sig_o;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   frm_slave_tx #(.NUM_TS(NUM_TS), .T1_CH(T1_CH), .SYNC_STAGES(2)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .ser_clk_i      (ser_clk_i),
      .fp_i           (fp_i),
      .cfg_fp_fall_i  (cfg_fp_fall_i),
      .cfg_dat_fall_i (cfg_dat_fall_i),
      .cfg_x2_i       (cfg_x2_i),
      .cfg_x2_late_i  (cfg_x2_late_i),
      .cfg_fp_inv_i   (cfg_fp_inv_i),
      .cfg_e1_i       (cfg_e1_i),
      .cfg_bit_ofs_i  (cfg_bit_ofs_i),
      .cfg_ch_ofs_i   (cfg_ch_ofs_i),
      .t1_fbit_i      (t1_fbit_i),
      .slot_data_i    (slot_data_i),
      .slot_sig_i     (slot_sig_i),
      .ser_dat_o      (ser_dat_o),
      .ser_sig_o      (ser_sig_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         n_err = n_err + 1;
         $display("FAIL watchdog: run did not end, got %0d cycles expected < 190000", cyc);
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   // Expected {data, signaling} for a stream position (R6 R7 R8 R9).
   function automatic logic [1:0] exp_out(int pos);
      int L  = cfg_e1_i ? 256 : 193;
      int om = (int'(cfg_ch_ofs_i) * 8 + int'(cfg_bit_ofs_i)) % L;
      int f  = (pos - om + L) % L;
      int g, ts, bb;
      logic d, s;
      if (!cfg_e1_i && f == 0) return {t1_fbit_i, 1'b0};
      g  = cfg_e1_i ? f : f - 1;
      ts = g / 8;
      bb = g % 8;
      d  = slot_data_i[ts*8 + 7 - bb];
      s  = (bb >= 4) ? slot_sig_i[ts*4 + 7 - bb] : 1'b0;
      return {d, s};
   endfunction

   function automatic bit is_pulse(int b, bit single, int L);
      if (single) return b == P0;
      return (b >= P0) && ((b - P0) % L == 0);
   endfunction

   task automatic chk(input string tag, input logic [1:0] ex);
      n_chk = n_chk + 1;
      if ({ser_dat_o, ser_sig_o} !== ex) begin
         n_err = n_err + 1;
         $display("FAIL %s: got dat/sig=%b expected %b at %0t", tag, {ser_dat_o, ser_sig_o}, ex, $time);
      end
   endtask

   task automatic run_case(input string tag, input bit e1v, input bit fpf, input bit datf,
                           input bit x2, input bit late, input bit inv,
                           input int bo, input int co, input bit single);
      int L;
      int nper;
      int ncyc;
      int nb;
      logic [1:0] ex;
      bit syn;
      rst_n = 1'b0;
      cfg_e1_i = e1v; cfg_fp_fall_i = fpf; cfg_dat_fall_i = datf;
      cfg_x2_i = x2; cfg_x2_late_i = late; cfg_fp_inv_i = inv;
      cfg_bit_ofs_i = 3'(bo); cfg_ch_ofs_i = 5'(co);
      t1_fbit_i = 1'($urandom);
      for (int t = 0; t < NUM_TS; t++) begin
         slot_data_i[t*8 +: 8] = 8'($urandom);
         slot_sig_i[t*4 +: 4]  = 4'($urandom);
      end
      ser_clk_i = 1'b0;
      fp_i = inv;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 reset state", 2'b00);
      L = e1v ? 256 : 193;
      nper = P0 + L + 40;
      ncyc = x2 ? 2 : 1;
      ex = 2'b00;
      syn = 1'b0;
      if (fpf) begin
         ser_clk_i = 1'b1;
         repeat (H) @(negedge clk);
      end
      for (int b = 0; b < nper; b++) begin
         for (int c = 0; c < ncyc; c++) begin
            // pulse-sampling edge
            chk(syn ? tag : "R1 idle before pulse", ex);
            ser_clk_i = ~fpf;
            if (datf == fpf && (!x2 || c == int'(late))) begin
               if (b >= P0) syn = 1'b1;
               ex = syn ? exp_out((b - P0) % L) : 2'b00;
            end
            repeat (H) @(negedge clk);
            // opposite edge: move the pulse for the next clock cycle
            chk(syn ? tag : "R1 idle before pulse", ex);
            ser_clk_i = fpf;
            nb = (c == ncyc - 1) ? b + 1 : b;
            fp_i = is_pulse(nb, single, L) ^ inv;
            if (datf != fpf && (!x2 || c == int'(late))) begin
               if (b >= P0) syn = 1'b1;
               ex = syn ? exp_out((b - P0) % L) : 2'b00;
            end
            repeat (H) @(negedge clk);
         end
      end
      chk(tag, ex);
   endtask

   initial begin
      void'($urandom(32'h5EED_2024));
      repeat (3) @(negedge clk);
      // R6 R9 R4: 256-bit frame, same edges, no delay
      run_case("R6 R9 R4 same-edge", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      // R7 R8 R2 R3: 193-bit frame, inverted pulse, data on falling edge
      run_case("R7 R8 R2 R3 split-edge", 0, 0, 1, 0, 0, 1, 5, 3, 0);
      // R5 R2 R3: double rate, update on the second edge, pulse on falling edge
      run_case("R5 R2 R3 x2-late", 1, 1, 0, 1, 1, 0, 2, 1, 0);
      // R5 R8: double rate, first edge, delay beyond the 193-bit frame
      run_case("R5 R8 x2-early ofs-wrap", 0, 1, 1, 1, 0, 1, 7, 30, 0);
      // R10: single pulse, the stream must keep wrapping
      run_case("R10 R8 free-run wrap", 1, 0, 1, 0, 0, 0, 3, 0, 1);
      for (int k = 0; k < 5; k++) begin
         run_case("R2 R3 R4 R5 R6 R7 R8 R9 random",
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), int'($urandom % 8), int'($urandom % 32), 0);
      end
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule